// File: doc/BRIEF.md
# TDMA Superframe Beacon Timer Unit

This unit derives the beacon period of a time-division superframe from the slot geometry and keeps four beacon-related alarms running against its own 64-bit microsecond time base. The period equals the number of slots multiplied by the slot length plus guard time. That product is rounded up to whole time units (TU, 1024 µs each), and an odd result is then raised by one so that the period in TU is always even. The guard time arrives already computed.

Software, or a neighbouring sequencer, gives the slot parameters and pulses one of two strobes. The initial-configuration strobe clears the time base and schedules the first beacon one period out. The reload strobe keeps the time base running and schedules the next beacon at a TU value supplied with it. Both strobes recompute the period, and both write every alarm target in the same clock cycle. The DMA-alert and software-beacon-alert alarms count in eighths of a TU. They lead the beacon by their own preparation offsets. The ATIM alarm trails the beacon by one TU. Only the station in slot 0 originates beacons. For that slot the strobe arms the beacon-alert interrupt and raises a one-cycle request for an immediate beacon.

All pins are plain control and status signals. The block has no streaming interface, so there is no valid/ready handshake and no back-pressure.

Top module: `tdma_beacon_sched`

## Requirements
- R1: On either strobe, the period in TU is ceil((slot length + guard) × slot count / 1024). It appears in bits [IVL_W-1:0] of `ivl_reg` one cycle after the strobe.
- R2: When the rounded period is odd, it is incremented by one, so `ivl_reg[0]` is 0 whenever the enable bit is set.
- R3: The enable flag is the MSB of `ivl_reg`. It is 0 after reset and 1 after any strobe. While it is 0, no bit of `tmr_fire` pulses.
- R4: The initial-configuration strobe sets `tsf_us` to 0 in the following cycle and sets the beacon target `tbtt_tu` to the new period.
- R5: After a strobe, `dba_t8` = 8 × `tbtt_tu` − DMA prep offset and `swba_t8` = 8 × `tbtt_tu` − beacon-alert prep offset, both in 1/8-TU units.
- R6: After a strobe, `atim_tu` = `tbtt_tu` + 1.
- R7: Slot index 0 sets `swba_irq_en` and pulses `beacon_now` for exactly one cycle after the strobe. Any other index clears `swba_irq_en` and leaves `beacon_now` low.
- R8: An alarm fires when the time base equals its target (target × 1024 µs for TU alarms, × 128 µs for 1/8-TU alarms). The `tmr_fire` bit is high in the next cycle, when `tsf_us` is one past that value. At the same time the target advances by one period (× 8 for 1/8-TU alarms). Bit order is 0 beacon, 1 DMA alert, 2 beacon alert, 3 ATIM.
- R9: The reload strobe loads `cfg_next_tbtt` as the beacon target and keeps the time base counting. All four targets change in that one cycle, and no `tmr_fire` bit is high in the cycle after any strobe.
- R10: `swba_irq` follows `tmr_fire[2]` only while `swba_irq_en` is set.
- R11: The time base `tsf_us` advances by one every clock cycle, except in the cycle after an initial-configuration strobe. Initial configuration takes priority over reload when both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one microsecond of the time base |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_slot_len_us | input | LEN_W | Slot length in µs |
| cfg_guard_us | input | LEN_W | Guard time per slot in µs |
| cfg_slot_cnt | input | CNT_W | Slots per superframe |
| cfg_slot_idx | input | SLOT_W | This station's slot index |
| cfg_dba_prep | input | PREP_W | DMA-alert lead in 1/8 TU |
| cfg_swba_prep | input | PREP_W | Beacon-alert lead in 1/8 TU |
| cfg_init | input | 1 | Initial-configuration strobe |
| cfg_load | input | 1 | Reload strobe |
| cfg_next_tbtt | input | TBTT_W | Beacon target in TU for reload |
| tsf_us | output | TSF_W | Free-running time base in µs |
| ivl_reg | output | IVL_W+1 | {enable, period in TU} |
| tbtt_tu | output | TBTT_W | Next beacon target in TU |
| dba_t8 | output | TBTT_W+3 | DMA-alert target in 1/8 TU |
| swba_t8 | output | TBTT_W+3 | Beacon-alert target in 1/8 TU |
| atim_tu | output | TBTT_W | ATIM target in TU |
| swba_irq_en | output | 1 | Beacon-alert interrupt enable |
| beacon_now | output | 1 | One-cycle immediate-beacon request |
| tmr_fire | output | 4 | Alarm expiry pulses |
| swba_irq | output | 1 | Gated beacon-alert interrupt |

## Verification
The vector table drives slot geometries whose raw period is odd, already even, exactly on a TU boundary, or just above one. A design that skips the round-up or the even fix-up reports a period one TU short or odd. The timed run counts the microsecond at which each alarm first and second fires. An off-by-one in the ×128 and ×1024 scaling, a missing prep subtraction, or a step not scaled by eight moves those instants. The reload test checks that the time base keeps running, that the targets jump together, and that no stray pulse follows. A slot-1 run confirms that a beacon alert without the interrupt enable never reaches `swba_irq`.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int TU_SHIFT   = 10;  // µs -> TU
  localparam int FINE_SHIFT = 7;   // µs -> 1/8 TU
  localparam int FINE_MUL   = 3;   // TU -> 1/8 TU

  typedef enum int {
    FIRE_TBTT = 0,
    FIRE_DBA  = 1,
    FIRE_SWBA = 2,
    FIRE_ATIM = 3
  } fire_idx_e;
endpackage

// File: rtl/tdma_ivl_calc.sv
module tdma_ivl_calc #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 8,
  parameter int IVL_W = LEN_W + CNT_W - 9
) (
  input  logic [LEN_W-1:0] slot_len,
  input  logic [LEN_W-1:0] guard,
  input  logic [CNT_W-1:0] slot_cnt,
  output logic [IVL_W-1:0] ivl_tu
);
  import tdma_pkg::*;
  localparam int SUM_W  = LEN_W + 1;
  localparam int PROD_W = SUM_W + CNT_W;

  logic [SUM_W-1:0]  per_slot;
  logic [PROD_W-1:0] frame_us;
  logic [PROD_W:0]   padded;
  logic [IVL_W-1:0]  whole_tu;

  assign per_slot = SUM_W'(slot_len) + SUM_W'(guard);
  assign frame_us = PROD_W'(per_slot) * PROD_W'(slot_cnt);
  // ceiling division by one TU
  assign padded   = (PROD_W+1)'(frame_us) + (PROD_W+1)'((1 << TU_SHIFT) - 1);
  assign whole_tu = IVL_W'(padded >> TU_SHIFT);
  // odd periods are pushed up to the next even value
  assign ivl_tu   = whole_tu + IVL_W'(whole_tu[0]);
endmodule

// File: rtl/tdma_alarm.sv
module tdma_alarm #(
  parameter int TSF_W  = 64,
  parameter int TGT_W  = 32,
  parameter int RES_SH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TSF_W-1:0] tsf,
  input  logic             en,
  input  logic             wr,
  input  logic [TGT_W-1:0] wr_val,
  input  logic [TGT_W-1:0] step,
  output logic [TGT_W-1:0] tgt,
  output logic             fire
);
  logic hit;

  assign hit = en && (tsf == (TSF_W'(tgt) << RES_SH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt  <= '0;
      fire <= 1'b0;
    end else if (wr) begin
      tgt  <= wr_val;
      fire <= 1'b0;
    end else begin
      fire <= hit;
      if (hit) tgt <= tgt + step;
    end
  end
endmodule

// File: rtl/tdma_beacon_sched.sv
module tdma_beacon_sched #(
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 8,
  parameter int SLOT_W = 8,
  parameter int PREP_W = 16,
  parameter int TBTT_W = 32,
  parameter int TSF_W  = 64,
  localparam int IVL_W   = LEN_W + 1 + CNT_W + 1 - tdma_pkg::TU_SHIFT,
  localparam int ALERT_W = TBTT_W + tdma_pkg::FINE_MUL
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   cfg_slot_len_us,
  input  logic [LEN_W-1:0]   cfg_guard_us,
  input  logic [CNT_W-1:0]   cfg_slot_cnt,
  input  logic [SLOT_W-1:0]  cfg_slot_idx,
  input  logic [PREP_W-1:0]  cfg_dba_prep,
  input  logic [PREP_W-1:0]  cfg_swba_prep,
  input  logic               cfg_init,
  input  logic               cfg_load,
  input  logic [TBTT_W-1:0]  cfg_next_tbtt,
  output logic [TSF_W-1:0]   tsf_us,
  output logic [IVL_W:0]     ivl_reg,
  output logic [TBTT_W-1:0]  tbtt_tu,
  output logic [ALERT_W-1:0] dba_t8,
  output logic [ALERT_W-1:0] swba_t8,
  output logic [TBTT_W-1:0]  atim_tu,
  output logic               swba_irq_en,
  output logic               beacon_now,
  output logic [3:0]         tmr_fire,
  output logic               swba_irq
);
  import tdma_pkg::*;

  logic               strobe;
  logic               slot_zero;
  logic [IVL_W-1:0]   ivl_new;
  logic [IVL_W-1:0]   ivl_q;
  logic               en_q;
  logic [TBTT_W-1:0]  sel_tbtt;
  logic [ALERT_W-1:0] tbtt_fine;

  logic [TBTT_W-1:0]  crs_wr   [2];
  logic [TBTT_W-1:0]  crs_tgt  [2];
  logic               crs_fire [2];
  logic [ALERT_W-1:0] fin_wr   [2];
  logic [ALERT_W-1:0] fin_tgt  [2];
  logic               fin_fire [2];
  logic [TBTT_W-1:0]  crs_step;
  logic [ALERT_W-1:0] fin_step;

  assign strobe    = cfg_init | cfg_load;
  assign slot_zero = (cfg_slot_idx == '0);

  tdma_ivl_calc #(.LEN_W(LEN_W), .CNT_W(CNT_W), .IVL_W(IVL_W)) u_ivl (
    .slot_len (cfg_slot_len_us),
    .guard    (cfg_guard_us),
    .slot_cnt (cfg_slot_cnt),
    .ivl_tu   (ivl_new)
  );

  // initial configuration wins over reload
  assign sel_tbtt  = cfg_init ? TBTT_W'(ivl_new) : cfg_next_tbtt;
  assign tbtt_fine = ALERT_W'(sel_tbtt) << FINE_MUL;

  assign crs_wr[0] = sel_tbtt;
  assign crs_wr[1] = sel_tbtt + TBTT_W'(1);
  assign fin_wr[0] = tbtt_fine - ALERT_W'(cfg_dba_prep);
  assign fin_wr[1] = tbtt_fine - ALERT_W'(cfg_swba_prep);

  assign crs_step = TBTT_W'(ivl_q);
  assign fin_step = ALERT_W'(ivl_q) << FINE_MUL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsf_us      <= '0;
      ivl_q       <= '0;
      en_q        <= 1'b0;
      swba_irq_en <= 1'b0;
      beacon_now  <= 1'b0;
    end else begin
      tsf_us     <= cfg_init ? '0 : tsf_us + TSF_W'(1);
      beacon_now <= strobe & slot_zero;
      if (strobe) begin
        ivl_q       <= ivl_new;
        en_q        <= 1'b1;
        swba_irq_en <= slot_zero;
      end
    end
  end

  // TU-resolution alarms: beacon (0) and ATIM (1)
  for (genvar g = 0; g < 2; g++) begin : g_crs
    tdma_alarm #(.TSF_W(TSF_W), .TGT_W(TBTT_W), .RES_SH(TU_SHIFT)) u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tsf    (tsf_us),
      .en     (en_q),
      .wr     (strobe),
      .wr_val (crs_wr[g]),
      .step   (crs_step),
      .tgt    (crs_tgt[g]),
      .fire   (crs_fire[g])
    );
  end

  // 1/8-TU alarms: DMA alert (0) and beacon alert (1)
  for (genvar g = 0; g < 2; g++) begin : g_fin
    tdma_alarm #(.TSF_W(TSF_W), .TGT_W(ALERT_W), .RES_SH(FINE_SHIFT)) u_alarm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tsf    (tsf_us),
      .en     (en_q),
      .wr     (strobe),
      .wr_val (fin_wr[g]),
      .step   (fin_step),
      .tgt    (fin_tgt[g]),
      .fire   (fin_fire[g])
    );
  end

  assign ivl_reg = {en_q, ivl_q};
  assign tbtt_tu = crs_tgt[0];
  assign atim_tu = crs_tgt[1];
  assign dba_t8  = fin_tgt[0];
  assign swba_t8 = fin_tgt[1];

  assign tmr_fire[FIRE_TBTT] = crs_fire[0];
  assign tmr_fire[FIRE_DBA]  = fin_fire[0];
  assign tmr_fire[FIRE_SWBA] = fin_fire[1];
  assign tmr_fire[FIRE_ATIM] = crs_fire[1];
  assign swba_irq = fin_fire[1] & swba_irq_en;
endmodule

// File: rtl/tdma_beacon_sched_chk.sv
module tdma_beacon_sched_chk #(
  parameter int IVL_W   = 16,
  parameter int TBTT_W  = 32,
  parameter int ALERT_W = 35,
  parameter int PREP_W  = 16,
  parameter int TSF_W   = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_init,
  input logic               cfg_load,
  input logic [PREP_W-1:0]  cfg_dba_prep,
  input logic [PREP_W-1:0]  cfg_swba_prep,
  input logic [TSF_W-1:0]   tsf_us,
  input logic [IVL_W:0]     ivl_reg,
  input logic [TBTT_W-1:0]  tbtt_tu,
  input logic [ALERT_W-1:0] dba_t8,
  input logic [ALERT_W-1:0] swba_t8,
  input logic [TBTT_W-1:0]  atim_tu,
  input logic               swba_irq_en,
  input logic               beacon_now,
  input logic [3:0]         tmr_fire,
  input logic               swba_irq
);
  a_r2_even_period: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_reg[IVL_W] |-> !ivl_reg[0]);

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ivl_reg[IVL_W] |-> (tmr_fire == 4'b0000));

  a_r4_init_zeroes_tsf: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |=> (tsf_us == '0));

  a_r5_dba_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_init || cfg_load) |=>
      (dba_t8 == (ALERT_W'(tbtt_tu) << 3) - ALERT_W'($past(cfg_dba_prep))));

  a_r5_swba_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_init || cfg_load) |=>
      (swba_t8 == (ALERT_W'(tbtt_tu) << 3) - ALERT_W'($past(cfg_swba_prep))));

  a_r6_atim_after: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_init || cfg_load) |=> (atim_tu == tbtt_tu + TBTT_W'(1)));

  a_r7_now_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    beacon_now |-> swba_irq_en);

  a_r8_tbtt_advance: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_fire[0] |-> (tbtt_tu == $past(tbtt_tu) + TBTT_W'(ivl_reg[IVL_W-1:0])));

  a_r9_no_fire_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_init || cfg_load) |=> (tmr_fire == 4'b0000));

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    swba_irq |-> (swba_irq_en && tmr_fire[2]));

  a_r11_tsf_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_init && $past(rst_n)) |=> (tsf_us == $past(tsf_us) + TSF_W'(1)));
endmodule

bind tdma_beacon_sched tdma_beacon_sched_chk #(
  .IVL_W(IVL_W), .TBTT_W(TBTT_W), .ALERT_W(ALERT_W),
  .PREP_W(PREP_W), .TSF_W(TSF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_load(cfg_load),
  .cfg_dba_prep(cfg_dba_prep), .cfg_swba_prep(cfg_swba_prep),
  .tsf_us(tsf_us), .ivl_reg(ivl_reg), .tbtt_tu(tbtt_tu), .dba_t8(dba_t8),
  .swba_t8(swba_t8), .atim_tu(atim_tu), .swba_irq_en(swba_irq_en),
  .beacon_now(beacon_now), .tmr_fire(tmr_fire), .swba_irq(swba_irq)
);

// File: tb/test_tdma_beacon_sched.sv
`timescale 1ns/1ps
module test_tdma_beacon_sched;
  localparam int IVL_W   = 16;
  localparam int TBTT_W  = 32;
  localparam int ALERT_W = 35;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [15:0]        slot_len = '0, guard = '0;
  logic [7:0]         slot_cnt = '0, slot_idx = '0;
  logic [15:0]        dba_prep = 16'd3, swba_prep = 16'd5;
  logic               init_s = 1'b0, load_s = 1'b0;
  logic [TBTT_W-1:0]  next_tbtt = '0;
  logic [63:0]        tsf;
  logic [IVL_W:0]     ivl_reg;
  logic [TBTT_W-1:0]  tbtt, atim;
  logic [ALERT_W-1:0] dba, swba;
  logic               irq_en, bnow, swba_irq;
  logic [3:0]         fire;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] grd;
    logic [7:0]  cnt;
    logic [7:0]  slot;
    logic [15:0] ivl;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{16'd1000, 16'd200,  8'd2, 8'd0, 16'd4},
    '{16'd1024, 16'd0,    8'd4, 8'd2, 16'd4},
    '{16'd500,  16'd12,   8'd2, 8'd0, 16'd2},
    '{16'd1000, 16'd25,   8'd1, 8'd1, 16'd2},
    '{16'd3000, 16'd1000, 8'd3, 8'd0, 16'd12},
    '{16'd2048, 16'd1024, 8'd3, 8'd7, 16'd10},
    '{16'd1,    16'd0,    8'd1, 8'd0, 16'd2}
  };

  tdma_beacon_sched i_tdma_beacon_sched (
    .clk(clk), .rst_n(rst_n),
    .cfg_slot_len_us(slot_len), .cfg_guard_us(guard),
    .cfg_slot_cnt(slot_cnt), .cfg_slot_idx(slot_idx),
    .cfg_dba_prep(dba_prep), .cfg_swba_prep(swba_prep),
    .cfg_init(init_s), .cfg_load(load_s), .cfg_next_tbtt(next_tbtt),
    .tsf_us(tsf), .ivl_reg(ivl_reg), .tbtt_tu(tbtt), .dba_t8(dba),
    .swba_t8(swba), .atim_tu(atim), .swba_irq_en(irq_en),
    .beacon_now(bnow), .tmr_fire(fire), .swba_irq(swba_irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input vec_t v);
    slot_len = v.len; guard = v.grd; slot_cnt = v.cnt; slot_idx = v.slot;
  endtask

  // strobe across one rising edge; returns at the following falling edge
  task automatic pulse(input bit is_init);
    @(negedge clk);
    if (is_init) init_s = 1'b1; else load_s = 1'b1;
    @(negedge clk);
    init_s = 1'b0; load_s = 1'b0;
  endtask

  logic [63:0] first_t [4];
  logic [63:0] second_t[4];
  logic [63:0] irq_t;
  int          irq_n;

  task automatic watch(input int ncyc);
    for (int k = 0; k < 4; k++) begin first_t[k] = '0; second_t[k] = '0; end
    irq_t = '0; irq_n = 0;
    for (int c = 0; c < ncyc; c++) begin
      for (int k = 0; k < 4; k++) begin
        if (fire[k]) begin
          if (first_t[k] == 0) first_t[k] = tsf;
          else if (second_t[k] == 0) second_t[k] = tsf;
        end
      end
      if (swba_irq) begin
        irq_n++;
        if (irq_t == 0) irq_t = tsf;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] t0;
    logic [3:0]  seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R3, R7)
    chk(ivl_reg == '0, "R3 reset ivl_reg", 64'(ivl_reg), 0);
    chk(tbtt == '0 && atim == '0, "R4 reset targets", 64'(tbtt), 0);
    chk(!irq_en && !bnow, "R7 reset irq_en/beacon_now", 64'({irq_en, bnow}), 0);
    seen = '0;
    for (int c = 0; c < 60; c++) begin
      seen |= fire;
      @(negedge clk);
    end
    chk(seen == 4'b0, "R3 no fire while disabled", 64'(seen), 0);

    // vector table: period, targets, slot-0 behaviour (R1 R2 R4 R5 R6 R7)
    for (int i = 0; i < 7; i++) begin
      set_cfg(VECS[i]);
      pulse(1'b1);
      chk(ivl_reg[IVL_W-1:0] == VECS[i].ivl, "R1/R2 period", 64'(ivl_reg[IVL_W-1:0]), 64'(VECS[i].ivl));
      chk(ivl_reg[IVL_W] == 1'b1, "R3 enable flag", 64'(ivl_reg[IVL_W]), 1);
      chk(tsf == 0, "R4 tsf cleared", tsf, 0);
      chk(tbtt == TBTT_W'(VECS[i].ivl), "R4 tbtt = period", 64'(tbtt), 64'(VECS[i].ivl));
      chk(dba == ALERT_W'(VECS[i].ivl) * 8 - 3, "R5 dba", 64'(dba), 64'(VECS[i].ivl) * 8 - 3);
      chk(swba == ALERT_W'(VECS[i].ivl) * 8 - 5, "R5 swba", 64'(swba), 64'(VECS[i].ivl) * 8 - 5);
      chk(atim == TBTT_W'(VECS[i].ivl) + 1, "R6 atim", 64'(atim), 64'(VECS[i].ivl) + 1);
      chk(irq_en == (VECS[i].slot == 0), "R7 irq_en", 64'(irq_en), 64'(VECS[i].slot == 0));
      chk(bnow == (VECS[i].slot == 0), "R7 beacon_now", 64'(bnow), 64'(VECS[i].slot == 0));
      chk(fire == 4'b0, "R9 quiet after strobe", 64'(fire), 0);
      @(negedge clk);
      chk(!bnow, "R7 beacon_now one cycle", 64'(bnow), 0);
    end

    // timed run, period 2 TU, slot 0 (R8 R10 R11)
    set_cfg(VECS[2]);
    pulse(1'b1);
    watch(4200);
    chk(first_t[2] == 64'd1409, "R8 swba first", first_t[2], 1409);
    chk(first_t[1] == 64'd1665, "R8 dba first", first_t[1], 1665);
    chk(first_t[0] == 64'd2049, "R8 tbtt first", first_t[0], 2049);
    chk(first_t[3] == 64'd3073, "R8 atim first", first_t[3], 3073);
    chk(second_t[2] == 64'd3457, "R8 swba second", second_t[2], 3457);
    chk(second_t[1] == 64'd3713, "R8 dba second", second_t[1], 3713);
    chk(second_t[0] == 64'd4097, "R8 tbtt second", second_t[0], 4097);
    chk(tbtt == 32'd6 && atim == 32'd5, "R8 targets advanced", 64'(tbtt), 6);
    chk(tsf == 64'd4200, "R11 tsf counts", tsf, 4200);
    chk(irq_n == 2 && irq_t == 64'd1409, "R10 irq with slot 0", irq_t, 1409);

    // slot 1: alert fires but interrupt stays off (R7 R10)
    set_cfg(VECS[3]);
    pulse(1'b1);
    chk(!irq_en && !bnow, "R7 non-zero slot", 64'({irq_en, bnow}), 0);
    watch(1500);
    chk(first_t[2] == 64'd1409, "R8 swba slot 1", first_t[2], 1409);
    chk(irq_n == 0, "R10 irq gated off", 64'(irq_n), 0);

    // reload: new period, supplied target, tsf keeps running (R9 R1)
    set_cfg(VECS[0]);
    slot_idx = 8'd0;
    next_tbtt = 32'd3;
    @(negedge clk);
    t0 = tsf;
    load_s = 1'b1;
    @(negedge clk);
    load_s = 1'b0;
    chk(tsf == t0 + 1, "R9 tsf not reset", tsf, t0 + 1);
    chk(tbtt == 32'd3 && atim == 32'd4, "R9 tbtt/atim loaded", 64'(tbtt), 3);
    chk(dba == 35'd21 && swba == 35'd19, "R9 alerts loaded", 64'(dba), 21);
    chk(ivl_reg[IVL_W-1:0] == 16'd4, "R1 period on reload", 64'(ivl_reg[IVL_W-1:0]), 4);
    chk(fire == 4'b0, "R9 quiet after load", 64'(fire), 0);
    watch(3200 - 32'(tsf));
    chk(first_t[0] == 64'd3073, "R9 tbtt after reload", first_t[0], 3073);

    // both strobes: init wins (R11)
    set_cfg(VECS[1]);
    next_tbtt = 32'd99;
    @(negedge clk);
    init_s = 1'b1; load_s = 1'b1;
    @(negedge clk);
    init_s = 1'b0; load_s = 1'b0;
    chk(tsf == 0 && tbtt == 32'd4, "R11 init priority", 64'(tbtt), 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule